// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block tracks which operating mode the digital core of a radio transceiver is in, and it sequences every move between modes. There are six modes: Off, Hibernate, Doze, Idle, Receive and Transmit. It drives the enables for the crystal oscillator, the receiver, the transmitter, the serial host port and the clock-out pin. It also drives an output-enable that tri-states the chip's digital pins, a ready flag, and an optional pin that shows when the block is out of Idle.

The host requests a mode with a 3-bit code and a one-cycle valid strobe. The block honours a request only in a steady, ready mode. An active-low attention pin wakes the block from Hibernate or Doze, and it passes through a two-stage synchroniser first. Doze can also end when an internal up-counter, started on entry to Doze, reaches a programmed compare value. Every settling delay is a down-counter loaded from a parameter given in clock cycles, so a bench can use short values.

States and transitions: `ST_OFF` (held while reset is low) goes to `ST_BOOT` on the first edge after reset is released. `ST_BOOT` goes to `ST_IDLE` when its count expires. `ST_IDLE` goes to `ST_HIB`, `ST_DOZE`, `ST_RX_WARM` or `ST_TX_WARM` on a request. `ST_HIB` goes to `ST_HIB_WAKE` on attention, and `ST_HIB_WAKE` goes to `ST_IDLE` when its count expires. `ST_DOZE` goes to `ST_DOZE_WAKE` on attention or on a timer match, and `ST_DOZE_WAKE` goes to `ST_IDLE` when its count expires. `ST_RX_WARM` goes to `ST_RX`, and `ST_TX_WARM` goes to `ST_TX`, when the count expires. `ST_RX` and `ST_TX` go back to `ST_IDLE` on an Idle request. An asynchronous reset sends any state to `ST_OFF`.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `rst_n` is low the block is in Off. The first rising edge after release enters a boot settle that lasts exactly `OFF_TICKS` cycles. `ready` goes high, in Idle, at edge `OFF_TICKS`+1 after release.
- R2: In Off, every output is low, including `out_oe`, the output-enable for the digital pins (1 = drive, 0 = tri-state). Lowering `rst_n` at any time forces Off at once. In every other mode `out_oe` is high.
- R3: In Idle with `ready` high and `req_valid` high, the request codes are 1 = Hibernate, 2 = Doze, 3 = Receive and 4 = Transmit, and each takes effect on the next edge. Codes 0, 5, 6 and 7 leave the block in Idle.
- R4: In Hibernate, `osc_en`, `spi_en`, `clko_en` and `ready` are low and requests are ignored. Only attention leaves Hibernate. It then enters a wake settle of exactly `HIB_TICKS` cycles, with `osc_en` high and `ready` low, and then returns to Idle.
- R5: In Doze, `osc_en` is high and `spi_en` is low, and requests are ignored. The doze timer starts at 0 on entry and counts one per cycle. With `doze_cmp_en` high and compare value K, Doze lasts K+1 cycles. With `doze_cmp_en` low, only attention ends Doze.
- R6: The Doze wake settle lasts `DOZE_TICKS` + 2^`clko_sel` cycles, the second term being one clock-out period. Then Idle follows.
- R7: `clko_en` is high in Idle, Receive, Transmit and their warm-ups. In Doze it is high only when `clko_doze_en` is 1 and `clko_sel` >= 4, where the clock-out rate is 16 MHz / 2^`clko_sel`, so a setting of 4 or more gives 1 MHz or less. It is low in every other mode.
- R8: A Receive or Transmit request first passes a warm-up of exactly `TRX_TICKS` cycles, with the matching `rx_en` or `tx_en` high and `ready` low. In Receive or Transmit only code 0 is honoured, and it returns to Idle on the next edge. `rx_en` and `tx_en` are never high together.
- R9: `ready` is low during every settle and warm-up, and a request that arrives then is dropped.
- R10: `attn_n` passes two flip-flops. A low level driven between edges e and e+1 changes the state at edge e+3. One cycle of low level is enough.
- R11: `out_idle_ind` is high when `out_idle_ind_en` is 1 and the mode is neither Idle nor Off. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset; low means Off |
| attn_n | input | 1 | Asynchronous active-low attention (wake) pin |
| req_valid | input | 1 | One-cycle strobe qualifying `req_mode` |
| req_mode | input | 3 | Requested mode code (see R3) |
| doze_cmp_en | input | 1 | Enables the Doze timer compare wake |
| doze_cmp_val | input | TMR_W | Doze timer compare value |
| clko_doze_en | input | 1 | Allows clock-out during Doze |
| clko_sel | input | 3 | Clock-out divider exponent (16 MHz / 2^n) |
| out_idle_ind_en | input | 1 | Enables the out-of-Idle indicator |
| osc_en | output | 1 | Oscillator enable |
| rx_en | output | 1 | Receiver enable |
| tx_en | output | 1 | Transmitter enable |
| spi_en | output | 1 | Host serial port gate |
| clko_en | output | 1 | Clock-out enable |
| out_oe | output | 1 | Digital output drive enable (0 = tri-state) |
| ready | output | 1 | Steady mode reached, requests accepted |
| out_idle_ind | output | 1 | Out-of-Idle indicator |

## Verification
The assertions assume three things. First, `req_valid` is sampled only at clock edges. Second, reset is never released within one cycle of being asserted, so the state seen one cycle earlier is a real state of the design. Third, the attention pin reaches the state machine only through the synchroniser, so a wake is always preceded by a synchronised wake level. The stimulus changes every input on the falling clock edge and keeps reset low for at least two cycles each time. It also drives `req_mode` only to codes that the requirements define, whether honoured or ignored. Attention pulses are exactly one cycle long, which checks that the synchroniser needs no stretched input.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_BOOT,
        ST_IDLE,
        ST_HIB,
        ST_HIB_WAKE,
        ST_DOZE,
        ST_DOZE_WAKE,
        ST_RX_WARM,
        ST_RX,
        ST_TX_WARM,
        ST_TX
    } pwr_state_e;

    typedef enum logic [2:0] {
        REQ_IDLE = 3'd0,
        REQ_HIB  = 3'd1,
        REQ_DOZE = 3'd2,
        REQ_RX   = 3'd3,
        REQ_TX   = 3'd4
    } pwr_req_e;

    // divider exponent from which clock-out is at or below 1 MHz
    localparam int unsigned CLKO_SLOW_SEL = 4;

endpackage

// File: rtl/pwr_attn_sync.sv
module pwr_attn_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic attn_n,
    output logic wake_o
);
    logic [STAGES-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], attn_n};
    end

    assign wake_o = ~sync_q[STAGES-1];
endmodule

// File: rtl/pwr_settle_ctr.sv
module pwr_settle_ctr #(
    parameter int unsigned CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt_q <= '0;
        else if (load_i)      cnt_q <= load_val_i;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    // R9: an expired settle count stays expired until reloaded (no wrap)
    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && zero_o) |=> zero_o);
endmodule

// File: rtl/pwr_doze_timer.sv
module pwr_doze_timer #(
    parameter int unsigned TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             run_i,
    input  logic             cmp_en_i,
    input  logic [TMR_W-1:0] cmp_val_i,
    output logic             match_o
);
    logic [TMR_W-1:0] tmr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      tmr_q <= '0;
        else if (clr_i)  tmr_q <= '0;
        else if (run_i)  tmr_q <= tmr_q + 1'b1;
    end

    assign match_o = cmp_en_i && (tmr_q == cmp_val_i);

    // R5: the timer starts from zero on Doze entry
    assert_tmr_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (tmr_q == '0));
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_mode_pkg::*;
#(
    parameter int unsigned OFF_TICKS   = 400000,
    parameter int unsigned HIB_TICKS   = 320000,
    parameter int unsigned DOZE_TICKS  = 4800,
    parameter int unsigned TRX_TICKS   = 2304,
    parameter int unsigned CNT_W       = 20,
    parameter int unsigned TMR_W       = 24,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             attn_n,
    input  logic             req_valid,
    input  logic [2:0]       req_mode,
    input  logic             doze_cmp_en,
    input  logic [TMR_W-1:0] doze_cmp_val,
    input  logic             clko_doze_en,
    input  logic [2:0]       clko_sel,
    input  logic             out_idle_ind_en,
    output logic             osc_en,
    output logic             rx_en,
    output logic             tx_en,
    output logic             spi_en,
    output logic             clko_en,
    output logic             out_oe,
    output logic             ready,
    output logic             out_idle_ind
);
    localparam logic [CNT_W-1:0] OFF_LOAD  = CNT_W'(OFF_TICKS - 1);
    localparam logic [CNT_W-1:0] HIB_LOAD  = CNT_W'(HIB_TICKS - 1);
    localparam logic [CNT_W-1:0] TRX_LOAD  = CNT_W'(TRX_TICKS - 1);
    localparam logic [CNT_W-1:0] DOZE_BASE = CNT_W'(DOZE_TICKS - 1);

    pwr_state_e       state_q, state_d;
    logic             attn_wake, tmr_match, ctr_zero;
    logic             ctr_load, tmr_clr;
    logic [CNT_W-1:0] ctr_val, doze_load;
    logic             doze_clk_ok;

    assign doze_load   = DOZE_BASE + (CNT_W'(1) << clko_sel);
    assign doze_clk_ok = clko_doze_en && (clko_sel >= 3'(CLKO_SLOW_SEL));

    pwr_attn_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .attn_n(attn_n), .wake_o(attn_wake)
    );

    pwr_settle_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load_i(ctr_load),
        .load_val_i(ctr_val), .zero_o(ctr_zero)
    );

    pwr_doze_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr),
        .run_i(state_q == ST_DOZE), .cmp_en_i(doze_cmp_en),
        .cmp_val_i(doze_cmp_val), .match_o(tmr_match)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d  = state_q;
        ctr_load = 1'b0;
        ctr_val  = '0;
        tmr_clr  = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                state_d  = ST_BOOT;
                ctr_load = 1'b1;
                ctr_val  = OFF_LOAD;
            end
            ST_BOOT:      if (ctr_zero) state_d = ST_IDLE;
            ST_IDLE: begin
                if (req_valid) begin
                    case (req_mode)
                        REQ_HIB:  state_d = ST_HIB;
                        REQ_DOZE: begin
                            state_d = ST_DOZE;
                            tmr_clr = 1'b1;
                        end
                        REQ_RX: begin
                            state_d  = ST_RX_WARM;
                            ctr_load = 1'b1;
                            ctr_val  = TRX_LOAD;
                        end
                        REQ_TX: begin
                            state_d  = ST_TX_WARM;
                            ctr_load = 1'b1;
                            ctr_val  = TRX_LOAD;
                        end
                        default: state_d = ST_IDLE;
                    endcase
                end
            end
            ST_HIB: begin
                if (attn_wake) begin
                    state_d  = ST_HIB_WAKE;
                    ctr_load = 1'b1;
                    ctr_val  = HIB_LOAD;
                end
            end
            ST_HIB_WAKE:  if (ctr_zero) state_d = ST_IDLE;
            ST_DOZE: begin
                if (attn_wake || tmr_match) begin
                    state_d  = ST_DOZE_WAKE;
                    ctr_load = 1'b1;
                    ctr_val  = doze_load;
                end
            end
            ST_DOZE_WAKE: if (ctr_zero) state_d = ST_IDLE;
            ST_RX_WARM:   if (ctr_zero) state_d = ST_RX;
            ST_TX_WARM:   if (ctr_zero) state_d = ST_TX;
            ST_RX, ST_TX: begin
                if (req_valid && (req_mode == REQ_IDLE)) state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        osc_en  = 1'b0;
        rx_en   = 1'b0;
        tx_en   = 1'b0;
        spi_en  = 1'b0;
        clko_en = 1'b0;
        out_oe  = 1'b1;
        ready   = 1'b0;
        unique case (state_q)
            ST_OFF:       out_oe = 1'b0;
            ST_BOOT, ST_HIB_WAKE, ST_DOZE_WAKE: osc_en = 1'b1;
            ST_HIB:       osc_en = 1'b0;
            ST_DOZE: begin
                osc_en  = 1'b1;
                clko_en = doze_clk_ok;
            end
            ST_IDLE: begin
                osc_en = 1'b1; spi_en = 1'b1; clko_en = 1'b1; ready = 1'b1;
            end
            ST_RX_WARM, ST_RX: begin
                osc_en = 1'b1; spi_en = 1'b1; clko_en = 1'b1; rx_en = 1'b1;
                ready  = (state_q == ST_RX);
            end
            ST_TX_WARM, ST_TX: begin
                osc_en = 1'b1; spi_en = 1'b1; clko_en = 1'b1; tx_en = 1'b1;
                ready  = (state_q == ST_TX);
            end
        endcase
        out_idle_ind = out_idle_ind_en && (state_q != ST_IDLE) && (state_q != ST_OFF);
    end

    // R8: radio paths are exclusive
    assert_rx_tx_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_en && tx_en));

    // R3: a ready block always has its host port and oscillator running
    assert_ready_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (spi_en && osc_en));

    // R4: Hibernate is left only after a synchronised attention level
    assert_hib_wake_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_HIB && state_q != ST_HIB) |-> $past(attn_wake));

    // R5: Doze is left only on attention or a timer match
    assert_doze_wake_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_DOZE && state_q != ST_DOZE)
            |-> $past(attn_wake || tmr_match));
endmodule

// File: tb/pwr_mode_seq_bench.sv
`timescale 1ns/1ps
module pwr_mode_seq_bench;
    localparam int OFF_T  = 8;
    localparam int HIB_T  = 6;
    localparam int DOZE_T = 5;
    localparam int TRX_T  = 4;
    localparam int CNT_W  = 20;
    localparam int TMR_W  = 8;

    localparam int B_OFF = 0, B_BOOT = 1, B_IDLE = 2, B_HIB = 3, B_HWAKE = 4,
                   B_DOZE = 5, B_DWAKE = 6, B_RXW = 7, B_RX = 8, B_TXW = 9, B_TX = 10;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic             rst_n, attn_n, req_valid, doze_cmp_en, clko_doze_en, out_idle_ind_en;
    logic [2:0]       req_mode, clko_sel;
    logic [TMR_W-1:0] doze_cmp_val;
    logic osc_en, rx_en, tx_en, spi_en, clko_en, out_oe, ready, out_idle_ind;

    pwr_mode_seq #(
        .OFF_TICKS(OFF_T), .HIB_TICKS(HIB_T), .DOZE_TICKS(DOZE_T),
        .TRX_TICKS(TRX_T), .CNT_W(CNT_W), .TMR_W(TMR_W), .SYNC_STAGES(2)
    ) u_pwr_mode_seq (
        .clk(clk), .rst_n(rst_n), .attn_n(attn_n), .req_valid(req_valid),
        .req_mode(req_mode), .doze_cmp_en(doze_cmp_en), .doze_cmp_val(doze_cmp_val),
        .clko_doze_en(clko_doze_en), .clko_sel(clko_sel),
        .out_idle_ind_en(out_idle_ind_en), .osc_en(osc_en), .rx_en(rx_en),
        .tx_en(tx_en), .spi_en(spi_en), .clko_en(clko_en), .out_oe(out_oe),
        .ready(ready), .out_idle_ind(out_idle_ind)
    );

    typedef struct {
        int         cyc;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sbq[$];
    int    cyc = 0;
    int    n_checks = 0;
    int    n_err = 0;
    bit    done = 1'b0;

    // expected outputs {out_oe,osc_en,spi_en,rx_en,tx_en,clko_en,ready,out_idle_ind}
    function automatic logic [7:0] ev(int s);
        logic alt, dz;
        alt = out_idle_ind_en;
        dz  = clko_doze_en && (clko_sel >= 3'd4);
        case (s)
            B_OFF:   ev = 8'b0;
            B_BOOT:  ev = {7'b1100000, alt};
            B_IDLE:  ev = 8'b11100110;
            B_HIB:   ev = {7'b1000000, alt};
            B_HWAKE: ev = {7'b1100000, alt};
            B_DOZE:  ev = {5'b11000, dz, 1'b0, alt};
            B_DWAKE: ev = {7'b1100000, alt};
            B_RXW:   ev = {7'b1111010, alt};
            B_RX:    ev = {7'b1111011, alt};
            B_TXW:   ev = {7'b1110110, alt};
            B_TX:    ev = {7'b1110111, alt};
            default: ev = 8'hxx;
        endcase
    endfunction

    task automatic push(int d, int s, string tag);
        item_t it;
        it.cyc = cyc + d;
        it.exp = ev(s);
        it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_req(logic [2:0] code);
        req_valid = 1'b1;
        req_mode  = code;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: pops expectations due in this cycle and compares
    always @(posedge clk) begin
        item_t      it;
        logic [7:0] got;
        cyc = cyc + 1;
        #1;
        got = {out_oe, osc_en, spi_en, rx_en, tx_en, clko_en, ready, out_idle_ind};
        while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
            it = sbq.pop_front();
            n_checks++;
            if (got !== it.exp) begin
                n_err++;
                $display("FAIL %s (cycle %0d): got %b expected %b", it.tag, cyc, got, it.exp);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; attn_n = 1'b1; req_valid = 1'b0; req_mode = 3'd0;
        doze_cmp_en = 1'b0; doze_cmp_val = '0; clko_doze_en = 1'b0;
        clko_sel = 3'd0; out_idle_ind_en = 1'b1;
        wait_cyc(2);

        // R1/R2: reset state and boot sequence, request during boot dropped (R9)
        push(1, B_OFF, "R2 all outputs low in reset");
        wait_cyc(1);
        rst_n = 1'b1;
        push(1, B_BOOT, "R1 boot settle entered");
        push(OFF_T, B_BOOT, "R1 ready still low at end of boot");
        push(OFF_T + 1, B_IDLE, "R1 idle after boot, R9 boot request dropped");
        wait_cyc(2);
        send_req(3'd3);
        wait_cyc(OFF_T - 2);

        // R3: undefined and idle codes ignored
        req_valid = 1'b1; req_mode = 3'd0;
        push(1, B_IDLE, "R3 code 0 ignored");
        push(2, B_IDLE, "R3 code 5 ignored");
        push(3, B_IDLE, "R3 code 7 ignored");
        wait_cyc(1); req_mode = 3'd5;
        wait_cyc(1); req_mode = 3'd7;
        wait_cyc(1); req_valid = 1'b0;

        // R8/R9: receive warm-up, request during warm-up dropped
        push(1, B_RXW, "R8 rx warm-up");
        push(TRX_T, B_RXW, "R8 rx warm-up last cycle");
        push(TRX_T + 1, B_RX, "R8 rx ready, R9 warm-up request dropped");
        send_req(3'd3);
        send_req(3'd4);
        wait_cyc(TRX_T - 1);
        push(1, B_RX, "R8 tx request ignored in rx");
        send_req(3'd4);
        push(1, B_IDLE, "R8 idle request leaves rx");
        send_req(3'd0);

        // R8/R11: transmit with indicator disabled
        out_idle_ind_en = 1'b0;
        push(1, B_TXW, "R11 indicator masked in tx warm-up");
        push(TRX_T + 1, B_TX, "R8 tx ready");
        send_req(3'd4);
        wait_cyc(TRX_T);
        push(1, B_IDLE, "R8 idle request leaves tx");
        send_req(3'd0);
        out_idle_ind_en = 1'b1;

        // R4/R10: hibernate, request ignored, wake by one-cycle attention
        push(1, B_HIB, "R4 hibernate entered");
        push(2, B_HIB, "R4 request ignored in hibernate");
        send_req(3'd1);
        send_req(3'd0);
        wait_cyc(2);
        attn_n = 1'b0;
        push(1, B_HIB, "R10 first sync stage");
        push(2, B_HIB, "R10 second sync stage");
        push(3, B_HWAKE, "R10 wake on third edge");
        push(HIB_T + 2, B_HWAKE, "R4 hibernate settle last cycle");
        push(HIB_T + 3, B_IDLE, "R4 idle after hibernate settle");
        wait_cyc(1);
        attn_n = 1'b1;
        wait_cyc(HIB_T + 2);

        // R5/R6/R7: doze, timer compare 3, clko_sel 4 with doze clock bit
        clko_sel = 3'd4; clko_doze_en = 1'b1; doze_cmp_en = 1'b1; doze_cmp_val = 8'd3;
        push(1, B_DOZE, "R7 clock-out kept in doze at sel 4");
        push(4, B_DOZE, "R5 doze lasts compare+1 cycles, request ignored");
        push(5, B_DWAKE, "R5 timer match wakes");
        push(4 + DOZE_T + 16, B_DWAKE, "R6 doze settle last cycle sel 4");
        push(5 + DOZE_T + 16, B_IDLE, "R6 idle after doze settle sel 4");
        send_req(3'd2);
        send_req(3'd1);
        wait_cyc(3 + DOZE_T + 16);

        // R5/R6/R7: compare disabled, attention wake, sel 3
        clko_sel = 3'd3; doze_cmp_en = 1'b0; doze_cmp_val = 8'd0;
        push(1, B_DOZE, "R7 clock-out off in doze at sel 3");
        push(4, B_DOZE, "R5 disabled compare does not wake");
        push(5, B_DWAKE, "R5 attention wakes doze");
        push(4 + DOZE_T + 8, B_DWAKE, "R6 doze settle last cycle sel 3");
        push(5 + DOZE_T + 8, B_IDLE, "R6 idle after doze settle sel 3");
        send_req(3'd2);
        wait_cyc(1);
        attn_n = 1'b0;
        wait_cyc(1);
        attn_n = 1'b1;
        wait_cyc(5 + DOZE_T + 8 - 3);

        // R6/R7: doze clock bit clear, sel 6, compare 1
        clko_sel = 3'd6; clko_doze_en = 1'b0; doze_cmp_en = 1'b1; doze_cmp_val = 8'd1;
        push(1, B_DOZE, "R7 clock-out off with doze bit clear");
        push(2, B_DOZE, "R5 compare 1 gives two doze cycles");
        push(3, B_DWAKE, "R5 timer match wakes");
        push(2 + DOZE_T + 64, B_DWAKE, "R6 doze settle last cycle sel 6");
        push(3 + DOZE_T + 64, B_IDLE, "R6 idle after doze settle sel 6, R7 clock-out in idle");
        send_req(3'd2);
        wait_cyc(2 + DOZE_T + 64);

        // R2/R1: asynchronous reset during Idle, then reboot
        rst_n = 1'b0;
        push(1, B_OFF, "R2 reset forces off");
        wait_cyc(2);
        rst_n = 1'b1;
        push(1, B_BOOT, "R1 reboot settle");
        push(OFF_T + 1, B_IDLE, "R1 idle after reboot");
        wait_cyc(OFF_T + 1);

        while (sbq.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule